// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Error Flags

This block is the receive half of a PC-style asynchronous serial port. It watches a serial input that idles high, using an enable strobe that pulses sixteen times per bit period. The input first passes through a synchroniser and a glitch filter. The receiver then finds the falling edge of a start bit and confirms that the line is still low at the middle of that bit. From that point it samples each following bit near its centre, timing from the start bit just found. Because timing restarts on every start bit, clock mismatch builds up over one character only.

Each character carries 5 to 8 data bits, least significant bit first, then an optional parity bit and one stop bit. Once the stop bit has been sampled, the character goes into a receive buffer and the data-ready flag is raised. The block also keeps four sticky error flags: overrun, parity, framing and break. A status-read strobe clears the four error flags. A buffer-read strobe clears data-ready. A loopback select takes the receiver input from the local transmit stream in place of the pin.

Top module: `uart_rx_core`

## Requirements
- R1: One bit lasts 16 pulses of `os_tick`. Characters are received correctly whatever the spacing of those pulses is in clock cycles.
- R2: A low pulse on the line that lasts fewer than 2 consecutive `os_tick` samples is ignored. It neither starts a character nor sets any flag.
- R3: After a falling edge, the line must still be low at the middle of the start bit. If it is not, the receiver returns to idle and no character is produced.
- R4: `word_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first. `rx_data` is zero-extended above the received bits.
- R5: When `parity_en` is 1, one parity bit follows the data. With `parity_even` = 1, the data bits and the parity bit together must hold an even number of ones. With `parity_even` = 0 they must hold an odd number. A mismatch sets `parity_err`.
- R6: Only one stop bit is checked. A new start bit may come straight after that one stop bit, and both characters are received.
- R7: A stop bit sampled as 0 sets `framing_err`.
- R8: When the data bits, the parity bit and the stop bit are all 0, the receiver sets both `break_flag` and `framing_err`. It then waits for the line to go high before it looks for another start bit.
- R9: A completed character loads `rx_data` and sets `data_ready`. `rx_data` changes at no other time. A `buf_rd` pulse clears `data_ready`.
- R10: If a character completes while `data_ready` is set and no `buf_rd` comes in the same cycle, `overrun_err` is set. The older byte stays in `rx_data` and the new character is dropped.
- R11: A `lsr_rd` pulse clears `overrun_err`, `parity_err`, `framing_err` and `break_flag`, and leaves `data_ready` as it is. If a completion arrives in the same cycle, its new flags win.
- R12: With `loop_en` = 1 the receiver takes `loop_tx` as its input and ignores `rx_pin`.
- R13: After reset, `rx_data` is 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Enable strobe at 16 times the bit rate |
| rx_pin | input | 1 | Serial input pin, idles high |
| loop_en | input | 1 | 1 takes the receiver input from `loop_tx` |
| loop_tx | input | 1 | Local transmit stream used in loopback |
| word_len | input | 2 | Number of data bits minus 5 |
| parity_en | input | 1 | 1 expects a parity bit |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| buf_rd | input | 1 | Single-cycle read of the receive buffer |
| lsr_rd | input | 1 | Single-cycle read of the line status |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | A character is waiting in the buffer |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity flag |
| framing_err | output | 1 | Sticky framing flag |
| break_flag | output | 1 | Sticky break flag |

## Verification
The bench builds the block with its default parameters: 16 samples per bit, a two-sample glitch filter, a two-stage synchroniser and an 8-bit data path. With these values all four word lengths are reachable, and both the glitch-rejection and false-start windows can be hit with pulses a few clocks long. The bench also changes the spacing of `os_tick` from every cycle to every third cycle, to show that bit timing follows the strobe and not the clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP,
      ST_HOLD
   } rx_state_e;

   typedef struct packed {
      logic parity_bad;
      logic frame_bad;
      logic brk;
   } rx_err_t;
endpackage

// File: rtl/urx_line_filter.sv
module urx_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TICKS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic os_tick,
   input  logic rx_pin,
   input  logic loop_en,
   input  logic loop_tx,
   output logic line_q
);
   localparam int FCW = (FILT_TICKS < 2) ? 1 : $clog2(FILT_TICKS + 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("urx_line_filter: SYNC_STAGES must be at least 1");
   end
   if (FILT_TICKS < 1) begin : g_bad_filt
      $error("urx_line_filter: FILT_TICKS must be at least 1");
   end

   logic              raw_in;
   logic [SYNC_STAGES-1:0] sync_q;
   logic [FCW-1:0]    fcnt;

   assign raw_in = loop_en ? loop_tx : rx_pin;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= raw_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b1;
         fcnt   <= '0;
      end else if (os_tick) begin
         if (sync_q[SYNC_STAGES-1] != line_q) begin
            if (fcnt == FCW'(FILT_TICKS - 1)) begin
               line_q <= sync_q[SYNC_STAGES-1];
               fcnt   <= '0;
            end else begin
               fcnt <= fcnt + 1'b1;
            end
         end else begin
            fcnt <= '0;
         end
      end
   end
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
   import uart_rx_pkg::*;
#(
   parameter int OS         = 16,
   parameter int FILT_TICKS = 2,
   parameter int DW         = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic          line_q,
   input  logic [1:0]    word_len,
   input  logic          parity_en,
   input  logic          parity_even,
   output logic          done,
   output logic [DW-1:0] word,
   output rx_err_t       err
);
   localparam int CW  = $clog2(OS);
   localparam int LW  = $clog2(DW + 1);
   localparam int MID = OS / 2 - 1 - FILT_TICKS;

   if (OS < 8 || MID < 0) begin : g_bad_os
      $error("urx_frame_fsm: OS too small for the filter delay");
   end
   if (DW < 4) begin : g_bad_dw
      $error("urx_frame_fsm: DW must be at least 4");
   end

   rx_state_e       state;
   logic [CW-1:0]   cnt;
   logic [LW-1:0]   bit_idx;
   logic [LW-1:0]   nbits;
   logic [DW-1:0]   shreg;
   logic [DW-1:0]   aligned;
   logic            par_acc;
   logic            all_zero;
   logic            bit_end;

   assign nbits   = LW'(DW - 3) + LW'(word_len);
   assign aligned = shreg >> (LW'(DW) - nbits);
   assign bit_end = (cnt == CW'(OS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_acc  <= 1'b0;
         all_zero <= 1'b1;
         done     <= 1'b0;
         word     <= '0;
         err      <= '0;
      end else begin
         done <= 1'b0;
         if (os_tick) begin
            case (state)
               ST_IDLE: begin
                  if (!line_q) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == CW'(MID)) begin
                     cnt <= '0;
                     if (!line_q) begin
                        state    <= ST_DATA;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        all_zero <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (bit_end) begin
                     cnt      <= '0;
                     shreg    <= {line_q, shreg[DW-1:1]};
                     par_acc  <= par_acc ^ line_q;
                     all_zero <= all_zero & ~line_q;
                     if (bit_idx == nbits - 1'b1)
                        state <= parity_en ? ST_PARITY : ST_STOP;
                     else
                        bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PARITY: begin
                  if (bit_end) begin
                     cnt      <= '0;
                     par_acc  <= par_acc ^ line_q;
                     all_zero <= all_zero & ~line_q;
                     state    <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (bit_end) begin
                     cnt            <= '0;
                     done           <= 1'b1;
                     word           <= aligned;
                     err.parity_bad <= parity_en & (par_acc ^ ~parity_even);
                     err.frame_bad  <= ~line_q;
                     err.brk        <= all_zero & ~line_q;
                     state          <= line_q ? ST_IDLE : ST_HOLD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_HOLD: begin
                  if (line_q) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/urx_status_bank.sv
module urx_status_bank
   import uart_rx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] word,
   input  rx_err_t       err,
   input  logic          buf_rd,
   input  logic          lsr_rd,
   output logic [DW-1:0] rx_data,
   output logic          data_ready,
   output logic          overrun_err,
   output logic          parity_err,
   output logic          framing_err,
   output logic          break_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         data_ready  <= 1'b0;
         overrun_err <= 1'b0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         break_flag  <= 1'b0;
      end else begin
         if (buf_rd) data_ready <= 1'b0;
         if (lsr_rd) begin
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_flag  <= 1'b0;
         end
         if (done) begin
            if (data_ready && !buf_rd) begin
               overrun_err <= 1'b1;
            end else begin
               rx_data    <= word;
               data_ready <= 1'b1;
               if (err.parity_bad) parity_err  <= 1'b1;
               if (err.frame_bad)  framing_err <= 1'b1;
               if (err.brk)        break_flag  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int OS          = 16,
   parameter int FILT_TICKS  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic          rx_pin,
   input  logic          loop_en,
   input  logic          loop_tx,
   input  logic [1:0]    word_len,
   input  logic          parity_en,
   input  logic          parity_even,
   input  logic          buf_rd,
   input  logic          lsr_rd,
   output logic [DW-1:0] rx_data,
   output logic          data_ready,
   output logic          overrun_err,
   output logic          parity_err,
   output logic          framing_err,
   output logic          break_flag
);
   logic          line_q;
   logic          word_done;
   logic [DW-1:0] word_val;
   rx_err_t       word_err;

   urx_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_TICKS  (FILT_TICKS)
   ) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .os_tick (os_tick),
      .rx_pin  (rx_pin),
      .loop_en (loop_en),
      .loop_tx (loop_tx),
      .line_q  (line_q)
   );

   urx_frame_fsm #(
      .OS         (OS),
      .FILT_TICKS (FILT_TICKS),
      .DW         (DW)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .os_tick     (os_tick),
      .line_q      (line_q),
      .word_len    (word_len),
      .parity_en   (parity_en),
      .parity_even (parity_even),
      .done        (word_done),
      .word        (word_val),
      .err         (word_err)
   );

   urx_status_bank #(
      .DW (DW)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (word_done),
      .word        (word_val),
      .err         (word_err),
      .buf_rd      (buf_rd),
      .lsr_rd      (lsr_rd),
      .rx_data     (rx_data),
      .data_ready  (data_ready),
      .overrun_err (overrun_err),
      .parity_err  (parity_err),
      .framing_err (framing_err),
      .break_flag  (break_flag)
   );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          word_done,
   input logic          buf_rd,
   input logic          lsr_rd,
   input logic [DW-1:0] rx_data,
   input logic          data_ready,
   input logic          overrun_err,
   input logic          parity_err,
   input logic          framing_err,
   input logic          break_flag
);
   assert_ready_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(word_done));

   assert_buf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd && !word_done |=> !data_ready);

   assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |=> $stable(rx_data));

   assert_overrun_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready && word_done && !buf_rd |=> overrun_err && $stable(rx_data));

   assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd && !word_done |=> !(overrun_err || parity_err || framing_err || break_flag));

   assert_break_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      break_flag |-> framing_err);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_done   (word_done),
   .buf_rd      (buf_rd),
   .lsr_rd      (lsr_rd),
   .rx_data     (rx_data),
   .data_ready  (data_ready),
   .overrun_err (overrun_err),
   .parity_err  (parity_err),
   .framing_err (framing_err),
   .break_flag  (break_flag)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx_pin = 1'b1;
   logic       loop_en = 1'b0;
   logic       loop_tx = 1'b1;
   logic [1:0] word_len = 2'd3;
   logic       parity_en = 1'b0;
   logic       parity_even = 1'b1;
   logic       buf_rd = 1'b0;
   logic       lsr_rd = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready, overrun_err, parity_err, framing_err, break_flag;

   int checks = 0;
   int errors = 0;
   int tick_div = 1;
   int tcnt = 0;
   logic to_loop = 1'b0;

   uart_rx_core u_dut (
      .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .rx_pin (rx_pin),
      .loop_en (loop_en), .loop_tx (loop_tx), .word_len (word_len),
      .parity_en (parity_en), .parity_even (parity_even),
      .buf_rd (buf_rd), .lsr_rd (lsr_rd), .rx_data (rx_data),
      .data_ready (data_ready), .overrun_err (overrun_err),
      .parity_err (parity_err), .framing_err (framing_err),
      .break_flag (break_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (tcnt >= tick_div - 1) begin
         tcnt    <= 0;
         os_tick <= 1'b1;
      end else begin
         tcnt    <= tcnt + 1;
         os_tick <= 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic drive_level(input logic v, input int n);
      if (to_loop) loop_tx = v;
      else         rx_pin  = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input logic use_par,
                             input logic par_bit, input logic stop_bit);
      int bitc;
      bitc = 16 * tick_div;
      drive_level(1'b0, bitc);
      for (int i = 0; i < nb; i++) drive_level(d[i], bitc);
      if (use_par) drive_level(par_bit, bitc);
      drive_level(stop_bit, bitc);
      drive_level(1'b1, bitc);
   endtask

   task automatic pulse_buf_rd();
      buf_rd = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_lsr_rd();
      lsr_rd = 1'b1;
      @(negedge clk);
      lsr_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_all();
      pulse_lsr_rd();
      pulse_buf_rd();
   endtask

   task automatic t_reset();
      check("R13 rx_data", rx_data, 0);
      check("R13 data_ready", data_ready, 0);
      check("R13 flags", {overrun_err, parity_err, framing_err, break_flag}, 0);
   endtask

   task automatic t_basic();
      word_len = 2'd3;
      send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
      check("R1 R4 8-bit data", rx_data, 8'hA5);
      check("R9 data_ready set", data_ready, 1);
      check("R7 no framing error", framing_err, 0);
      pulse_buf_rd();
      check("R9 buf_rd clears ready", data_ready, 0);
      tick_div = 3;
      repeat (4) @(negedge clk);
      send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1);
      check("R1 slow tick data", rx_data, 8'h6E);
      check("R1 slow tick ready", data_ready, 1);
      pulse_buf_rd();
      tick_div = 1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_lengths();
      word_len = 2'd0;
      send_frame(8'h16, 5, 1'b0, 1'b0, 1'b1);
      check("R4 5-bit data", rx_data, 8'h16);
      pulse_buf_rd();
      word_len = 2'd2;
      send_frame(8'h5A, 7, 1'b0, 1'b0, 1'b1);
      check("R4 7-bit data", rx_data, 8'h5A);
      pulse_buf_rd();
      word_len = 2'd1;
      send_frame(8'h3F, 6, 1'b0, 1'b0, 1'b1);
      check("R4 6-bit data", rx_data, 8'h3F);
      pulse_buf_rd();
      word_len = 2'd3;
   endtask

   task automatic t_parity();
      parity_en = 1'b1;
      parity_even = 1'b1;
      send_frame(8'h37, 8, 1'b1, 1'b1, 1'b1);
      check("R5 even parity good", parity_err, 0);
      check("R5 even parity data", rx_data, 8'h37);
      clear_all();
      send_frame(8'h37, 8, 1'b1, 1'b0, 1'b1);
      check("R5 even parity bad", parity_err, 1);
      clear_all();
      parity_even = 1'b0;
      send_frame(8'h37, 8, 1'b1, 1'b0, 1'b1);
      check("R5 odd parity good", parity_err, 0);
      clear_all();
      send_frame(8'h37, 8, 1'b1, 1'b1, 1'b1);
      check("R5 odd parity bad", parity_err, 1);
      clear_all();
      parity_en = 1'b0;
      parity_even = 1'b1;
   endtask

   task automatic t_framing();
      send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0);
      check("R7 framing error", framing_err, 1);
      check("R7 not a break", break_flag, 0);
      check("R7 data kept", rx_data, 8'h55);
      clear_all();
   endtask

   task automatic t_break();
      int bitc;
      bitc = 16;
      drive_level(1'b0, bitc * 10);
      check("R8 break flag", break_flag, 1);
      check("R8 break framing", framing_err, 1);
      check("R8 break data", rx_data, 0);
      pulse_buf_rd();
      drive_level(1'b0, bitc * 12);
      check("R8 held low gives no new word", data_ready, 0);
      drive_level(1'b1, bitc * 2);
      clear_all();
      send_frame(8'h81, 8, 1'b0, 1'b0, 1'b1);
      check("R8 recovery data", rx_data, 8'h81);
      check("R8 recovery no break", break_flag, 0);
      pulse_buf_rd();
   endtask

   task automatic t_glitch();
      for (int k = 0; k < 4; k++) begin
         drive_level(1'b0, 1);
         drive_level(1'b1, 40);
      end
      check("R2 glitch ignored", data_ready, 0);
      check("R2 glitch no flags", {overrun_err, parity_err, framing_err, break_flag}, 0);
      send_frame(8'h42, 8, 1'b0, 1'b0, 1'b1);
      check("R2 frame after glitch", rx_data, 8'h42);
      pulse_buf_rd();
   endtask

   task automatic t_false_start();
      drive_level(1'b0, 4);
      drive_level(1'b1, 200);
      check("R3 false start no word", data_ready, 0);
      check("R3 false start no flags", {overrun_err, parity_err, framing_err, break_flag}, 0);
      send_frame(8'h24, 8, 1'b0, 1'b0, 1'b1);
      check("R3 frame after false start", rx_data, 8'h24);
      pulse_buf_rd();
   endtask

   task automatic t_overrun();
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
      send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
      check("R10 overrun flag", overrun_err, 1);
      check("R10 older byte kept", rx_data, 8'h11);
      pulse_lsr_rd();
      check("R11 lsr_rd clears overrun", overrun_err, 0);
      check("R11 lsr_rd keeps ready", data_ready, 1);
      pulse_buf_rd();
      check("R9 ready cleared", data_ready, 0);
   endtask

   task automatic t_back_to_back();
      logic [7:0] first_seen;
      first_seen = 8'h00;
      fork
         begin
            drive_level(1'b0, 16);
            for (int i = 0; i < 8; i++) drive_level(8'hC3 >> i, 16);
            drive_level(1'b1, 16);
            send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
         end
         begin
            while (!data_ready) @(negedge clk);
            first_seen = rx_data;
            pulse_buf_rd();
         end
      join
      check("R6 first of pair", first_seen, 8'hC3);
      check("R6 second of pair", rx_data, 8'h3C);
      check("R6 no overrun", overrun_err, 0);
      check("R6 no framing", framing_err, 0);
      pulse_buf_rd();
   endtask

   task automatic t_loopback();
      loop_en = 1'b1;
      repeat (4) @(negedge clk);
      rx_pin = 1'b0;
      repeat (200) @(negedge clk);
      check("R12 pin ignored in loopback", data_ready, 0);
      to_loop = 1'b1;
      send_frame(8'h9D, 8, 1'b0, 1'b0, 1'b1);
      to_loop = 1'b0;
      check("R12 loopback data", rx_data, 8'h9D);
      check("R12 loopback no framing", framing_err, 0);
      rx_pin = 1'b1;
      repeat (8) @(negedge clk);
      loop_en = 1'b0;
      clear_all();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_basic();
      t_lengths();
      t_parity();
      t_framing();
      t_break();
      t_glitch();
      t_false_start();
      t_overrun();
      t_back_to_back();
      t_loopback();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule